// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block connects a processor-side request port to an asynchronous DRAM whose row and column addresses share one set of address pins. The processor raises a request together with a full word address and a write flag. The controller captures all three on the edge where it accepts them. It then places the upper part of the address on the shared pins while holding the row strobe low. After a programmable delay it switches the pins to the lower part and lowers the column strobe. The controller drives chip select and the write-enable line itself. The data bus connects the processor to the memory directly and does not pass through this block.

The controller keeps its own refresh counter. A free-running interval timer raises a refresh demand once per programmed number of cycles. The next time the controller is idle, it runs a row-only strobe cycle using the refresh counter as the row. The counter then advances to the next row. A refresh is never started in the middle of an access. A request that arrives while the controller is busy stays stalled through a ready handshake until the controller can take it.

Top module: `mux_dram_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `ras_n`, `cas_n`, `cs_n` and `we_n` are all 1, `ready` is 1 and `done` is 0.
- R2: A request is taken on a rising edge where `req` and `ready` are both 1. In the following cycle `ras_n` is 0, `cas_n` is 1, `cs_n` is 0, and `mem_addr` carries the row, which is `addr[ADDR_W-1:COL_W]` zero-extended to the pin width.
- R3: `ras_n` stays low with `cas_n` high for exactly `T_RCD` cycles. Then `cas_n` is low for exactly `T_CAS` cycles, with `ras_n` still low and `mem_addr` carrying `addr[COL_W-1:0]` zero-extended.
- R4: Throughout the access, `we_n` is 0 when the accepted `wr` was 1 (write) and 1 when it was 0 (read).
- R5: `done` is high for exactly one cycle, in the first cycle after `cas_n` returns high. In that same cycle `ras_n` is also high. After any strobe cycle, `ras_n` stays high for at least `T_RP` cycles before it falls again.
- R6: `ready` is 0 whenever `ras_n` is low. A request held high while the controller is busy is served later, and no request is lost. The address and write flag used are the values present on the accept edge, even if the inputs change afterwards.
- R7: About once every `REF_INTERVAL` cycles, a refresh runs. During a refresh, `ras_n` is low for exactly `T_REF_RAS` cycles, `cas_n` stays 1, `we_n` stays 1, `cs_n` is 0, and `mem_addr` carries the refresh row.
- R8: The refresh row is 0 for the first refresh after reset. It rises by one after each refresh and wraps to 0 after 2^`ROW_W` - 1.
- R9: A pending refresh wins over a waiting request at the next idle point. While a refresh is pending, `ready` is 0. A refresh never cuts short an access in progress, so refreshes keep occurring under a continuous request stream.
- R10: A refresh cycle produces no `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Processor request strobe, held until accepted |
| addr | input | ROW_W+COL_W | Full word address, row in the upper bits |
| wr | input | 1 | 1 = write, 0 = read |
| ready | output | 1 | Controller can accept a request on this edge |
| done | output | 1 | One-cycle completion pulse after the column phase |
| mem_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
A wrong sequencer state or timing count shows up at once at the strobe pins. A strobe phase that is too short or too long is visible when `cas_n` falls or `ras_n` rises. A `done` that is early or missing is visible in the cycle after `cas_n` rises. A faulty capture register shows up on `mem_addr` during the first row or column phase that follows. A corrupted refresh counter only shows up at the next refresh, up to `REF_INTERVAL` cycles later, when the row on the pins no longer matches the next value in sequence. A lost refresh demand shows up as a refresh count that falls short over a long idle window.

// File: rtl/mdc_pkg.sv
`timescale 1ns/1ps
// Shared types for the multiplexed-address DRAM controller.
package mdc_pkg;
    // Sequencer phases; ROW/COL/PRE form an access, REF/PRE a refresh.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_PRE  = 3'd3,
        ST_REF  = 3'd4
    } mdc_state_e;
endpackage

// File: rtl/mdc_refresh.sv
`timescale 1ns/1ps
// Refresh demand generator and row counter.
// Raises a pending flag every REF_INTERVAL cycles, cleared when the
// sequencer starts a refresh; steps the row counter at refresh end.
// Assumes REF_INTERVAL >= 2 and that one refresh completes well
// within an interval (a second expiry while pending merges).
module mdc_refresh #(
    parameter int REF_INTERVAL = 1560,
    parameter int ROW_W        = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_start_i,
    input  logic             ref_end_i,
    output logic             pending_o,
    output logic [ROW_W-1:0] ref_row_o
);
    localparam int TMR_W = $clog2(REF_INTERVAL);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REF_INTERVAL - 1);

    logic [TMR_W-1:0] tmr_q;
    logic             expire;

    assign expire = (tmr_q == TMR_LAST);

    // Free-running interval timer.
    always_ff @(posedge clk) begin
        if (!rst_n)      tmr_q <= '0;
        else if (expire) tmr_q <= '0;
        else             tmr_q <= tmr_q + 1'b1;
    end

    // Pending flag: set on expiry, cleared when refresh is launched.
    always_ff @(posedge clk) begin
        if (!rst_n)           pending_o <= 1'b0;
        else if (expire)      pending_o <= 1'b1;
        else if (ref_start_i) pending_o <= 1'b0;
    end

    // Row counter, advanced once per completed refresh, wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)         ref_row_o <= '0;
        else if (ref_end_i) ref_row_o <= ref_row_o + 1'b1;
    end

    // R8: each refresh moves the row on by exactly one, modulo rows.
    p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_end_i |=> (ref_row_o == ROW_W'($past(ref_row_o) + 1'b1)));

    // R9: a demand is not forgotten until a refresh is launched.
    p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !ref_start_i) |=> pending_o);
endmodule

// File: rtl/mdc_seq.sv
`timescale 1ns/1ps
// Strobe sequencer. Walks ROW -> COL -> PRE for an access and
// REF -> PRE for a refresh, each phase lasting a parameter count.
// Refresh wins over a request only in IDLE; no phase is cut short.
// Assumes every timing parameter is at least 1.
module mdc_seq
    import mdc_pkg::*;
#(
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_RP      = 2,
    parameter int T_REF_RAS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       ref_pend_i,
    output mdc_state_e state_o,
    output logic       ready_o,
    output logic       accept_o,
    output logic       ref_start_o,
    output logic       ref_end_o,
    output logic       done_o,
    output logic       ras_n_o,
    output logic       cas_n_o,
    output logic       cs_n_o
);
    localparam int TMAX_A = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int TMAX_B = (T_RP > T_REF_RAS) ? T_RP : T_REF_RAS;
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int CNT_W  = (TMAX < 2) ? 1 : $clog2(TMAX);

    mdc_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;
    logic             done_q;

    assign last        = (cnt_q == '0);
    assign ready_o     = (state_q == ST_IDLE) && !ref_pend_i;
    assign accept_o    = ready_o && req_i;
    assign ref_start_o = (state_q == ST_IDLE) && ref_pend_i;
    assign ref_end_o   = (state_q == ST_REF) && last;
    assign state_o     = state_q;
    assign done_o      = done_q;

    // Phase register and down-counter for the current phase length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (ref_pend_i) begin
                        state_q <= ST_REF;
                        cnt_q   <= CNT_W'(T_REF_RAS - 1);
                    end else if (req_i) begin
                        state_q <= ST_ROW;
                        cnt_q   <= CNT_W'(T_RCD - 1);
                    end
                end
                ST_ROW: begin
                    if (last) begin
                        state_q <= ST_COL;
                        cnt_q   <= CNT_W'(T_CAS - 1);
                    end else cnt_q <= cnt_q - 1'b1;
                end
                ST_COL, ST_REF: begin
                    if (last) begin
                        state_q <= ST_PRE;
                        cnt_q   <= CNT_W'(T_RP - 1);
                    end else cnt_q <= cnt_q - 1'b1;
                end
                ST_PRE: begin
                    if (last) state_q <= ST_IDLE;
                    else      cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Completion pulse for the cycle after the column phase ends.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_COL) && last;
    end

    // Strobe decode from the phase register.
    always_comb begin
        ras_n_o = !((state_q == ST_ROW) || (state_q == ST_COL) || (state_q == ST_REF));
        cas_n_o = (state_q != ST_COL);
        cs_n_o  = (state_q == ST_IDLE) || (state_q == ST_PRE);
    end

    // R3: the column strobe only ever appears inside an open row.
    p_cas_in_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n_o |-> !ras_n_o);

    // R5: completion follows a column strobe.
    p_done_after_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(!cas_n_o) && cas_n_o && ras_n_o));

    // R2: an accepted request opens a row on the next cycle.
    p_accept_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (!ras_n_o && cas_n_o && !cs_n_o));

    // R6: no acceptance while a strobe is active.
    p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (ras_n_o && cas_n_o));

    // R9: the refresh path is taken when a demand is seen in idle.
    p_ref_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_start_o |=> (!ras_n_o && cas_n_o));
endmodule

// File: rtl/mdc_addr_mux.sv
`timescale 1ns/1ps
// Address capture and pin multiplexer. Latches row, column and write
// flag on acceptance, then presents row, column or refresh row on the
// shared pins according to the sequencer phase.
module mdc_addr_mux
    import mdc_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 9,
    parameter int PIN_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept_i,
    input  logic [ROW_W+COL_W-1:0] addr_i,
    input  logic                   wr_i,
    input  mdc_state_e             state_i,
    input  logic [ROW_W-1:0]       ref_row_i,
    output logic [PIN_W-1:0]       pin_addr_o,
    output logic                   we_n_o
);
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             wr_q;

    // Capture the request fields on the accept edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
            wr_q  <= 1'b0;
        end else if (accept_i) begin
            row_q <= addr_i[ROW_W+COL_W-1:COL_W];
            col_q <= addr_i[COL_W-1:0];
            wr_q  <= wr_i;
        end
    end

    // Phase-dependent pin selection and write-enable.
    always_comb begin
        case (state_i)
            ST_ROW:  pin_addr_o = PIN_W'(row_q);
            ST_COL:  pin_addr_o = PIN_W'(col_q);
            ST_REF:  pin_addr_o = PIN_W'(ref_row_i);
            default: pin_addr_o = '0;
        endcase
        we_n_o = !(wr_q && ((state_i == ST_ROW) || (state_i == ST_COL)));
    end

    // R3: the column value is steady across the column phase.
    p_col_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_COL && $past(state_i) == ST_COL) |-> $stable(pin_addr_o));

    // R7: write enable never asserts during a refresh.
    p_ref_no_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_REF) |-> we_n_o);
endmodule

// File: rtl/mux_dram_ctrl.sv
`timescale 1ns/1ps
// Top of the multiplexed-address DRAM controller. Joins the refresh
// generator, strobe sequencer and address multiplexer. Data lines do
// not pass through this block.
module mux_dram_ctrl #(
    parameter int ROW_W        = 12,
    parameter int COL_W        = 9,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 2,
    parameter int T_REF_RAS    = 3,
    parameter int REF_INTERVAL = 1560,
    localparam int ADDR_W      = ROW_W + COL_W,
    localparam int PIN_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              ready,
    output logic              done,
    output logic [PIN_W-1:0]  mem_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              cs_n,
    output logic              we_n
);
    import mdc_pkg::*;

    mdc_state_e       state;
    logic             accept;
    logic             ref_pend;
    logic             ref_start;
    logic             ref_end;
    logic [ROW_W-1:0] ref_row;

    mdc_refresh #(
        .REF_INTERVAL (REF_INTERVAL),
        .ROW_W        (ROW_W)
    ) u_refresh (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_start_i (ref_start),
        .ref_end_i   (ref_end),
        .pending_o   (ref_pend),
        .ref_row_o   (ref_row)
    );

    mdc_seq #(
        .T_RCD     (T_RCD),
        .T_CAS     (T_CAS),
        .T_RP      (T_RP),
        .T_REF_RAS (T_REF_RAS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .ref_pend_i  (ref_pend),
        .state_o     (state),
        .ready_o     (ready),
        .accept_o    (accept),
        .ref_start_o (ref_start),
        .ref_end_o   (ref_end),
        .done_o      (done),
        .ras_n_o     (ras_n),
        .cas_n_o     (cas_n),
        .cs_n_o      (cs_n)
    );

    mdc_addr_mux #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .PIN_W (PIN_W)
    ) u_amux (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .addr_i     (addr),
        .wr_i       (wr),
        .state_i    (state),
        .ref_row_i  (ref_row),
        .pin_addr_o (mem_addr),
        .we_n_o     (we_n)
    );

    // R1/R5: chip select follows the row strobe's active window.
    p_cs_with_ras_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cs_n);

    // R10: a refresh row strobe ends without a completion pulse.
    p_ref_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_REF && state == ST_PRE) |-> !done);
endmodule

// File: tb/sim_mux_dram_ctrl.sv
`timescale 1ns/1ps
module sim_mux_dram_ctrl;
    localparam int ROW_W = 4, COL_W = 3;
    localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_REF_RAS = 3;
    localparam int REF_INTERVAL = 40;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int PIN_W = 4;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic ready, done, ras_n, cas_n, cs_n, we_n;
    logic [PIN_W-1:0] mem_addr;

    always #2 clk = ~clk;

    mux_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
                    .T_RP(T_RP), .T_REF_RAS(T_REF_RAS), .REF_INTERVAL(REF_INTERVAL)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wr(wr),
        .ready(ready), .done(done), .mem_addr(mem_addr),
        .ras_n(ras_n), .cas_n(cas_n), .cs_n(cs_n), .we_n(we_n));

    typedef struct packed { logic [PIN_W-1:0] row; logic [PIN_W-1:0] col; logic we_n; } exp_t;
    exp_t exp_q[$];

    int n_tests = 0, n_fail = 0;
    int served = 0, issued = 0, ref_count = 0;
    bit mon_en = 0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // Driver: raise a request, wait for ready, record the expectation.
    task automatic issue(input logic [ADDR_W-1:0] a, input logic w);
        exp_t e;
        @(negedge clk);
        req = 1'b1; addr = a; wr = w;
        while (!ready) @(negedge clk);
        e.row = PIN_W'(a[ADDR_W-1:COL_W]);
        e.col = PIN_W'(a[COL_W-1:0]);
        e.we_n = !w;
        exp_q.push_back(e);
        issued++;
        @(negedge clk);
        req = 1'b0; addr = ~a; wr = ~w;   // disturb inputs after acceptance (R6)
    endtask

    // Monitor: follows strobes and compares against the scoreboard.
    logic prev_ras = 1'b1, prev_cas = 1'b1;
    int ras_len = 0, cas_len = 0, gap = 1000;
    bit cas_seen = 0, we_cap = 1;
    logic [PIN_W-1:0] row_cap = '0;
    logic [ROW_W-1:0] ref_model = '0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (!ras_n && !ready) ; else if (!ras_n) check(0, "R6 ready during strobe", 1, 0);
            if (!ras_n && prev_ras) begin
                check(gap >= T_RP, "R5 precharge gap", gap, T_RP);
                check(cas_n && !cs_n, "R2 row phase strobes", {30'd0, cas_n, cs_n}, 2);
                row_cap = mem_addr; we_cap = we_n; cas_seen = 0; ras_len = 1;
            end else if (!ras_n) ras_len++;
            if (ras_n && !prev_ras) gap = 1; else if (ras_n) gap++;

            if (!cas_n && prev_cas) begin
                exp_t e;
                check(ras_len == T_RCD + 1, "R3 row-to-column delay", ras_len - 1, T_RCD);
                if (exp_q.size() == 0) check(0, "R6 unexpected access", 0, 1);
                else begin
                    e = exp_q.pop_front();
                    check(row_cap == e.row, "R2 row address", row_cap, e.row);
                    check(mem_addr == e.col, "R3 column address", mem_addr, e.col);
                    check(we_n == e.we_n && we_cap == e.we_n, "R4 write enable", we_n, e.we_n);
                    served++;
                end
                cas_seen = 1; cas_len = 1;
            end else if (!cas_n) cas_len++;

            if (cas_n && !prev_cas) begin
                check(cas_len == T_CAS, "R3 column width", cas_len, T_CAS);
                check(done == 1'b1, "R5 done after column", done, 1);
                check(ras_n == 1'b1, "R5 row closes with done", ras_n, 1);
            end else if (done) check(0, "R5 stray done", 1, 0);

            if (ras_n && !prev_ras && !cas_seen) begin
                check(ras_len == T_REF_RAS, "R7 refresh width", ras_len, T_REF_RAS);
                check(we_cap == 1'b1, "R7 refresh we_n", we_cap, 1);
                check(row_cap == PIN_W'(ref_model), "R8 refresh row", row_cap, ref_model);
                check(done == 1'b0, "R10 no done on refresh", done, 0);
                ref_model = ref_model + 1'b1;
                ref_count++;
            end
            prev_ras = ras_n; prev_cas = cas_n;
        end
    end

    // Watchdog.
    initial begin
        #(4 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int r0;
        repeat (4) @(negedge clk);
        check({ras_n, cas_n, cs_n, we_n} == 4'hF, "R1 strobes idle in reset", {ras_n, cas_n, cs_n, we_n}, 15);
        check(ready == 1'b1 && done == 1'b0, "R1 ready/done in reset", {ready, done}, 2);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check({ras_n, cas_n, cs_n, we_n} == 4'hF, "R1 strobes idle after reset", {ras_n, cas_n, cs_n, we_n}, 15);
        check(ready == 1'b1 && done == 1'b0, "R1 ready after reset", {ready, done}, 2);
        mon_en = 1;

        // Single read and write, checked cycle by cycle by the monitor (R2-R5).
        issue(7'h5B, 1'b0);
        issue(7'h26, 1'b1);
        // Back-to-back mixed stream: hold-off and capture (R6).
        for (int i = 0; i < 6; i++) issue(ADDR_W'(i * 19 + 3), i[0]);
        repeat (12) @(negedge clk);
        check(served == issued, "R6 all requests served", served, issued);

        // Idle window: refresh cadence (R7).
        r0 = ref_count;
        repeat (10 * REF_INTERVAL) @(negedge clk);
        check((ref_count - r0) >= 9 && (ref_count - r0) <= 11, "R7 refresh rate idle",
              ref_count - r0, 10);

        // Continuous request stream: refresh still wins at idle points (R9).
        r0 = ref_count;
        for (int i = 0; i < 30; i++) issue(ADDR_W'(i * 37 + 11), i[1]);
        repeat (12) @(negedge clk);
        check((ref_count - r0) >= 4, "R9 refresh under load", ref_count - r0, 4);
        check(served == issued, "R9 no access lost under refresh", served, issued);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

        // Run long enough for the refresh row to wrap (R8).
        repeat (8 * REF_INTERVAL) @(negedge clk);
        check(ref_count > (1 << ROW_W), "R8 wrap exercised", ref_count, (1 << ROW_W) + 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule